// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Timer

This block generates pulse-width modulated outputs from one shared time base. A prescaler divides the clock by a power of two, and a 16-bit counter runs from zero up to a programmable modulo value and then wraps. Each wrap is an overflow, and it marks the boundary between PWM periods. Each of two compare channels watches the counter. It can force its output to a fixed level on a match and invert it on every overflow. Each channel's period and pulse width therefore come from the modulo and compare values.

The two channels can also be joined into one buffered output on channel 0's pin. Software then alternates between the two compare registers. It loads the idle register while the other one runs, and the idle register takes over at the next period boundary. This gives glitch-free width updates without timing the write against the counter. All settings are written through one write port with a small address.

Top module: `pwm_pair_timer`

Address map (`wr_addr_i`): 0 timer control (bit 0 halt, bit 1 counter clear, bits 4:2 divider select N); 1 modulo; 2 channel 0 config; 3 channel 0 compare; 4 channel 1 config; 5 channel 1 compare. Channel config bits: [1:0] mode, [2] invert on overflow, [4:3] compare action (2'b10 drive low, 2'b11 drive high).

## Requirements
- R1: With mode 2'b01, compare action 2'b10 and invert-on-overflow set, a channel with modulo M, compare C ≤ M and N = 0 is high for C+1 clock cycles out of every M+1.
- R2: With compare action 2'b11 and invert-on-overflow set, the channel is high for M−C cycles of every M+1, so C = M gives a constant low output.
- R3: The counter wraps to zero on the tick after it equals the modulo value. When a match and an overflow fall on the same tick, the overflow inversion is applied after the compare action, so C = M with action 2'b10 gives a constant high output.
- R4: The divider select N (control bits 4:2) makes the counter advance once every 2^N clocks, scaling both the period and the pulse width by 2^N.
- R5: While the halt bit (control bit 0) is set, the counter holds and both outputs stay unchanged.
- R6: Writing control with bit 1 set zeroes the counter and the prescaler. The bit is not retained, so later periods run at full length.
- R7: Mode 2'b10 on channel 0 links the pair into one buffered output on `pwm0_o`. The channel 0 compare register sets the width first.
- R8: In linked mode, a write to the idle compare register takes effect only from the next overflow. The running period keeps its width.
- R9: In linked mode, a write to the active compare register is used at once, within the running period.
- R10: At each overflow the active register becomes the one written last. Of several writes in one period, only the final one selects the register.
- R11: In linked mode, `pwm1_o` stays low whatever channel 1's config holds, and `ch1_gpio_o` is high to release the pin.
- R12: After reset both outputs are low, both channels are disabled (mode 2'b00), the counter runs undivided and `ch1_gpio_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| pwm0_o | output | 1 | Channel 0 output, also the buffered output |
| pwm1_o | output | 1 | Channel 1 output, low while linked |
| ch1_gpio_o | output | 1 | High when channel 1's pin is free for general use |

## Verification
The hardest situation to reach is a compare write that lands inside a known period of the linked output. Only then can deferred and immediate updates be told apart. The stimulus tracks every rising edge of `pwm0_o`, which in clear-on-compare mode marks an overflow. It issues the write a couple of cycles after that edge, well before any match, and then measures the length of this high pulse and the next one. The same alignment places two writes, to different registers, inside one period to show that only the last one selects the register.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 3;
  localparam int N_CH   = 2;

  localparam logic [ADDR_W-1:0] A_TMR = 3'd0;
  localparam logic [ADDR_W-1:0] A_MOD = 3'd1;
  localparam int CH_BASE = 2;  // channel g: cfg at CH_BASE+2g, cmp at +1

  localparam logic [1:0] MODE_SOLO = 2'b01;
  localparam logic [1:0] MODE_PAIR = 2'b10;

  typedef struct packed {
    logic       lvl_act;  // compare drives a level
    logic       lvl_set;  // level driven on compare
    logic       tov;      // invert on overflow
    logic [1:0] mode;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             ovf_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] presc_q, mask;
  logic [CNT_W-1:0] cnt_q;

  assign mask   = (PRE_W'(1) << div_i) - PRE_W'(1);
  assign tick_o = !halt_i && !clr_i && ((presc_q & mask) == mask);
  assign ovf_o  = tick_o && (cnt_q == mod_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      presc_q <= '0;
      cnt_q   <= '0;
    end else if (!halt_i) begin
      presc_q <= presc_q + PRE_W'(1);
      if (tick_o) cnt_q <= ovf_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
  a_r5_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_pingpong.sv
module pwm_pingpong (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic linked_i,
  input  logic ovf_i,
  input  logic wr0_i,
  input  logic wr1_i,
  output logic sel_o
);
  logic last_q, last_d, sel_q;

  assign last_d = wr1_i ? 1'b1 : (wr0_i ? 1'b0 : last_q);
  assign sel_o  = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (!linked_i) begin
      last_q <= 1'b0;  // channel 0 leads after linking
      sel_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      if (ovf_i) sel_q <= last_d;
    end
  end

  a_r8_sel_only_at_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (linked_i && !ovf_i) |=> $stable(sel_q));
endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
  import pwm_pair_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    hit_i,
  input  logic    ovf_i,
  input  ch_cfg_t cfg_i,
  output logic    q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) begin
      if (hit_i && cfg_i.lvl_act) q_d = cfg_i.lvl_set;
      if (ovf_i && cfg_i.tov)     q_d = !q_d;  // overflow after compare
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  a_r1_out_only_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && (hit_i || ovf_i)) |=> $stable(q_q));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CW = pwm_pair_pkg::CNT_W,
  parameter int AW = pwm_pair_pkg::ADDR_W,
  parameter int DW = pwm_pair_pkg::DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic          pwm0_o,
  output logic          pwm1_o,
  output logic          ch1_gpio_o
);
  logic          halt_q;
  logic [DW-1:0] div_q;
  logic [CW-1:0] mod_q;
  ch_cfg_t       cfg_q   [N_CH];
  logic [CW-1:0] cmp_q   [N_CH];
  logic [CW-1:0] cmp_act [N_CH];
  logic [N_CH-1:0] wr_cmp, en, hit, q;

  logic          clr, tick, ovf, linked, sel;
  logic [CW-1:0] cnt;

  assign clr = wr_en_i && (wr_addr_i == A_TMR) && wr_data_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      div_q  <= '0;
      mod_q  <= '1;
      for (int g = 0; g < N_CH; g++) begin
        cfg_q[g] <= '0;
        cmp_q[g] <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_addr_i == A_TMR) begin
        halt_q <= wr_data_i[0];
        div_q  <= wr_data_i[2 +: DW];
      end
      if (wr_addr_i == A_MOD) mod_q <= wr_data_i;
      for (int g = 0; g < N_CH; g++) begin
        if (wr_addr_i == AW'(CH_BASE + 2*g))     cfg_q[g] <= ch_cfg_t'(wr_data_i[CFG_W-1:0]);
        if (wr_addr_i == AW'(CH_BASE + 2*g + 1)) cmp_q[g] <= wr_data_i;
      end
    end
  end

  pwm_timebase #(.CNT_W(CW), .DIV_W(DW)) i_timebase (
    .clk_i, .rst_ni,
    .halt_i (halt_q),
    .clr_i  (clr),
    .div_i  (div_q),
    .mod_i  (mod_q),
    .cnt_o  (cnt),
    .tick_o (tick),
    .ovf_o  (ovf)
  );

  assign linked = (cfg_q[0].mode == MODE_PAIR);

  pwm_pingpong i_pingpong (
    .clk_i, .rst_ni,
    .linked_i (linked),
    .ovf_i    (ovf),
    .wr0_i    (wr_cmp[0]),
    .wr1_i    (wr_cmp[1]),
    .sel_o    (sel)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign wr_cmp[g] = wr_en_i && (wr_addr_i == AW'(CH_BASE + 2*g + 1));
    if (g == 0) begin : g_lead
      assign cmp_act[g] = (linked && sel) ? cmp_q[1] : cmp_q[0];
      assign en[g]      = (cfg_q[g].mode == MODE_SOLO) || linked;
    end else begin : g_follow
      assign cmp_act[g] = cmp_q[g];
      assign en[g]      = !linked && (cfg_q[g].mode == MODE_SOLO);
    end
    assign hit[g] = tick && (cnt == cmp_act[g]);

    pwm_out_chan i_chan (
      .clk_i, .rst_ni,
      .en_i  (en[g]),
      .hit_i (hit[g]),
      .ovf_i (ovf),
      .cfg_i (cfg_q[g]),
      .q_o   (q[g])
    );
  end

  assign pwm0_o     = q[0];
  assign pwm1_o     = q[1] && !linked;
  assign ch1_gpio_o = linked;

  a_r11_pair_mutes_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (linked && $past(linked)) |-> !pwm1_o && ch1_gpio_o);
endmodule

// File: tb/test_pwm_pair_timer.sv
module test_pwm_pair_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm0, pwm1, ch1_gpio;

  int checks = 0, fails = 0;
  int run = 0, last_run = 0, falls = 0, rises = 0;
  logic prev0 = 1'b0;
  bit done = 1'b0;

  always #2 clk = !clk;

  pwm_pair_timer i_pwm_pair_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm0_o(pwm0), .pwm1_o(pwm1), .ch1_gpio_o(ch1_gpio)
  );

  // high-pulse monitor on pwm0
  always @(negedge clk) begin
    if (pwm0) begin
      run <= prev0 ? run + 1 : 1;
      if (!prev0) rises <= rises + 1;
    end else if (prev0) begin
      last_run <= run;
      falls    <= falls + 1;
    end
    prev0 <= pwm0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_high(input int which, input int cycles, output int n);
    n = 0;
    repeat (cycles) begin
      @(negedge clk);
      if ((which == 0) ? pwm0 : pwm1) n++;
    end
  endtask

  task automatic wait_fall();
    int f = falls;
    while (falls == f) @(posedge clk);
  endtask

  task automatic wait_rise();
    int r = rises;
    while (rises == r) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 pwm0", int'(pwm0), 0);
    chk("R12 pwm1", int'(pwm1), 0);
    chk("R12 gpio", int'(ch1_gpio), 0);
  endtask

  task automatic t_solo();
    int n;
    wr(0, 16'h0003);         // halt + clear
    wr(1, 16'd9);
    wr(3, 16'd4);
    wr(5, 16'd6);
    wr(2, 16'h0015);         // solo, invert, drive low
    wr(4, 16'h001D);         // solo, invert, drive high
    wr(0, 16'h0000);
    repeat (25) @(negedge clk);
    count_high(0, 10, n); chk("R1 clear C=4 M=9", n, 5);
    count_high(1, 10, n); chk("R2 set C=6 M=9", n, 3);
    wr(3, 16'd9); wr(5, 16'd9);
    repeat (25) @(negedge clk);
    count_high(0, 10, n); chk("R3 clear C=M full high", n, 10);
    count_high(1, 10, n); chk("R2 set C=M zero", n, 0);
    wr(3, 16'd0);
    repeat (25) @(negedge clk);
    count_high(0, 10, n); chk("R1 clear C=0", n, 1);
  endtask

  task automatic t_divider();
    int n;
    wr(3, 16'd4); wr(5, 16'd6);
    wr(0, 16'h0008);         // N=2
    repeat (90) @(negedge clk);
    count_high(0, 40, n); chk("R4 N=2 ch0", n, 20);
    count_high(1, 40, n); chk("R4 N=2 ch1", n, 12);
    wr(0, 16'h0000);
    repeat (25) @(negedge clk);
  endtask

  task automatic t_halt_clear();
    int n, chg;
    logic p;
    wait_fall();
    wr(0, 16'h0001);
    chg = 0; p = pwm0;
    repeat (20) begin
      @(negedge clk);
      if (pwm0 != p) chg++;
      p = pwm0;
    end
    chk("R5 halted edges", chg, 0);
    chk("R5 halted level", int'(pwm0), 0);
    wr(0, 16'h0002);         // clear and run
    n = 0;
    while (!pwm0 && n < 100) begin n++; @(negedge clk); end
    chk("R6 low after clear", n, 10);
    wait_fall();
    wait_fall();
    chk("R6 next pulse normal", last_run, 5);
  endtask

  task automatic t_linked();
    int n;
    wr(0, 16'h0001);
    wr(1, 16'd15);
    wr(3, 16'd12);
    wr(5, 16'd3);
    wr(2, 16'h0016);         // pair, invert, drive low
    wr(4, 16'h0015);         // ignored while paired
    wr(0, 16'h0002);
    chk("R11 gpio released", int'(ch1_gpio), 1);
    count_high(1, 40, n); chk("R11 pwm1 muted", n, 0);
    wait_fall(); wait_fall();
    chk("R7 ch0 leads", last_run, 13);
    // deferred write to idle register
    wait_rise(); wr(5, 16'd3);
    wait_fall(); chk("R8 current period kept", last_run, 13);
    wait_fall(); chk("R8 switch at overflow", last_run, 4);
    // write to active register
    wait_rise(); wr(5, 16'd9);
    wait_fall(); chk("R9 active write immediate", last_run, 10);
    wait_fall(); chk("R9 value holds", last_run, 10);
    // two writes, last one wins
    wait_rise(); wr(3, 16'd5); wr(5, 16'd7);
    wait_fall(); chk("R10 active updated", last_run, 8);
    wait_fall(); chk("R10 last write wins", last_run, 8);
    wait_rise(); wr(3, 16'd2);
    wait_fall(); chk("R10 ch1 until overflow", last_run, 8);
    wait_fall(); chk("R10 back to ch0", last_run, 3);
    chk("R11 pwm1 still low", int'(pwm1), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL all: watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_solo();
    t_divider();
    t_halt_clear();
    t_linked();
    summary();
    $finish;
  end
endmodule